// File: doc/BRIEF.md
# Smart Card Status Flags and Request Generator

This block keeps the status flags of a serial port running in ISO 7816-style smart card mode. From those flags it drives the transmit, receive and error interrupt lines and the activation requests for a DMA or transfer controller. The transmit and receive engines report events to it as single-cycle strobes. A transmitted byte either completes cleanly or is refused by the card's error signal. A received byte arrives with or without a parity error. When the card refuses a byte, the block records the error and asks the transmit engine to send the same byte again. While that retry runs, no transmit-end status is raised and no DMA transfer is triggered.

The DMA engine acknowledges each transfer with a one-cycle pulse, which clears the data flags that the transfer serviced. Software clears a flag in two steps. First it reads the status while the flag is 1, then it writes a clear mask. The error-signal flag can be removed only this way. No data path passes through the block. Every pin is a plain control or status level or strobe, so there is no valid/ready handshake and no back-pressure.

Status bit positions: [0] transmit data empty, [1] transmit end, [2] receive full, [3] parity error, [4] overrun, [5] error signal.

Top module: `sc_irq_ctrl`

## Requirements
- R1: Reset leaves `status_o` at 6'b000011, meaning transmit empty and transmit end are 1 and every other bit is 0. It also leaves both DMA requests and `retx_req_o` low.
- R2: A `tx_end_i` strobe with `tx_nak_i` low sets status bits [0] and [1] at the same clock edge.
- R3: A `tx_end_i` strobe with `tx_nak_i` high sets bit [5] and leaves bits [0] and [1] unchanged. It also drives `retx_req_o` high for exactly the one cycle after the strobe.
- R4: `txi_o` equals status bit [1] AND `tie_i`, combinationally.
- R5: `rxi_o` equals status bit [2] AND `rie_i`, combinationally.
- R6: `eri_o` is high when `rie_i` is high and any of status bits [3], [4] or [5] is 1.
- R7: A `rx_end_i` strobe while bit [2] is 0 sets bit [2] when `rx_perr_i` is low. When `rx_perr_i` is high, it sets bit [3] and leaves bit [2] at 0.
- R8: A `rx_end_i` strobe while bit [2] is 1 sets bit [4]. The byte is discarded, so bit [2] stays 1 and bit [3] is untouched.
- R9: `dma_tx_ack_i` clears bits [0] and [1]. `dma_rx_ack_i` clears bit [2]. Neither acknowledge changes bits [3], [4] or [5].
- R10: `dma_tx_req_o` is high in the cycle after one in which `txi_o` is high and `dma_tx_ack_i` is low; otherwise it is low. `dma_rx_req_o` follows the same rule with `rxi_o` and `dma_rx_ack_i`. No error flag ever raises either request.
- R11: A `cpu_rd_i` strobe arms every status bit that is 1 at that moment. A `cpu_clr_i` strobe clears the bits that are both set in `cpu_clr_mask_i` and armed. Unarmed bits keep their value.
- R12: When a set event and a clear of the same bit fall in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_end_i | input | 1 | Strobe: transmitted byte finished |
| tx_nak_i | input | 1 | Qualifies tx_end_i: card signalled an error |
| rx_end_i | input | 1 | Strobe: byte received |
| rx_perr_i | input | 1 | Qualifies rx_end_i: parity error |
| tie_i | input | 1 | Transmit interrupt enable |
| rie_i | input | 1 | Receive and error interrupt enable |
| cpu_rd_i | input | 1 | Strobe: CPU read the status |
| cpu_clr_i | input | 1 | Strobe: CPU writes a clear mask |
| cpu_clr_mask_i | input | 6 | Bits to clear, same positions as status_o |
| dma_tx_ack_i | input | 1 | Pulse: DMA wrote new transmit data |
| dma_rx_ack_i | input | 1 | Pulse: DMA read received data |
| status_o | output | 6 | Status flags |
| txi_o | output | 1 | Transmit interrupt |
| rxi_o | output | 1 | Receive interrupt |
| eri_o | output | 1 | Error interrupt |
| dma_tx_req_o | output | 1 | Transmit DMA activation request |
| dma_rx_req_o | output | 1 | Receive DMA activation request |
| retx_req_o | output | 1 | Request to resend the current byte |

## Verification
Status bits, both DMA requests and the retransmit request are registered. Each is due exactly one clock edge after the strobe or acknowledge that causes it. The three interrupt lines add no register: they reflect the flags after that edge and the enables that are currently applied. The bench changes every input at the falling edge and pushes the expected post-edge values into a queue. The monitor pops and compares one entry 1 ns after the following rising edge, so every result is read in the one cycle where it is due.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
  localparam int NFLAG   = 6;
  localparam int FL_TXE  = 0;
  localparam int FL_TEND = 1;
  localparam int FL_RXF  = 2;
  localparam int FL_PAR  = 3;
  localparam int FL_OVR  = 4;
  localparam int FL_ESIG = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;

  localparam flag_vec_t FLAG_RST = flag_vec_t'((1 << FL_TXE) | (1 << FL_TEND));
endpackage

// File: rtl/sc_event_decode.sv
module sc_event_decode
  import sc_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_end_i,
  input  logic      tx_nak_i,
  input  logic      rx_end_i,
  input  logic      rx_perr_i,
  input  logic      rxf_i,
  input  logic      dma_tx_ack_i,
  input  logic      dma_rx_ack_i,
  output flag_vec_t set_o,
  output flag_vec_t hwclr_o,
  output logic      retx_o
);
  logic retx_q;

  // Hardware set events, one bit per flag
  always_comb begin
    set_o = '0;
    if (tx_end_i) begin
      if (tx_nak_i) begin
        set_o[FL_ESIG] = 1'b1;
      end else begin
        set_o[FL_TXE]  = 1'b1;
        set_o[FL_TEND] = 1'b1;
      end
    end
    if (rx_end_i) begin
      if (rxf_i)          set_o[FL_OVR] = 1'b1;
      else if (rx_perr_i) set_o[FL_PAR] = 1'b1;
      else                set_o[FL_RXF] = 1'b1;
    end
  end

  // Transfer acknowledges clear only the data flags they serviced
  always_comb begin
    hwclr_o          = '0;
    hwclr_o[FL_TXE]  = dma_tx_ack_i;
    hwclr_o[FL_TEND] = dma_tx_ack_i;
    hwclr_o[FL_RXF]  = dma_rx_ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retx_q <= 1'b0;
    else        retx_q <= tx_end_i & tx_nak_i;
  end
  assign retx_o = retx_q;

  a_r3_retx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end_i && tx_nak_i) |=> retx_o);
  a_r3_retx_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_end_i && tx_nak_i) |=> !retx_o);
endmodule

// File: rtl/sc_flag_bank.sv
module sc_flag_bank
  import sc_irq_pkg::*;
#(
  parameter flag_vec_t RST_VAL = FLAG_RST
) (
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_i,
  input  flag_vec_t hwclr_i,
  input  logic      cpu_rd_i,
  input  logic      cpu_clr_i,
  input  flag_vec_t cpu_mask_i,
  output flag_vec_t flags_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    logic flag_q, arm_q, cpu_kill, flag_nxt;

    assign cpu_kill = cpu_clr_i & cpu_mask_i[i] & arm_q;
    // set has priority over any clear source
    assign flag_nxt = set_i[i] | (flag_q & ~hwclr_i[i] & ~cpu_kill);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= RST_VAL[i];
        arm_q  <= 1'b0;
      end else begin
        flag_q <= flag_nxt;
        arm_q  <= (arm_q | (cpu_rd_i & flag_q)) & flag_nxt;
      end
    end
    assign flags_o[i] = flag_q;

    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);
    a_r11_unarmed_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[i] && !arm_q && !hwclr_i[i]) |=> flags_o[i]);
  end
endmodule

// File: rtl/sc_req_gen.sv
module sc_req_gen
  import sc_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags_i,
  input  logic      tie_i,
  input  logic      rie_i,
  input  logic      dma_tx_ack_i,
  input  logic      dma_rx_ack_i,
  output logic      txi_o,
  output logic      rxi_o,
  output logic      eri_o,
  output logic      dma_tx_req_o,
  output logic      dma_rx_req_o
);
  logic dtx_q, drx_q;

  assign txi_o = flags_i[FL_TEND] & tie_i;
  assign rxi_o = flags_i[FL_RXF] & rie_i;
  assign eri_o = (flags_i[FL_PAR] | flags_i[FL_OVR] | flags_i[FL_ESIG]) & rie_i;

  // only the transmit and receive interrupts may start a transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtx_q <= 1'b0;
      drx_q <= 1'b0;
    end else begin
      dtx_q <= txi_o & ~dma_tx_ack_i;
      drx_q <= rxi_o & ~dma_rx_ack_i;
    end
  end
  assign dma_tx_req_o = dtx_q;
  assign dma_rx_req_o = drx_q;

  a_r10_tx_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_ack_i |=> !dma_tx_req_o);
  a_r10_rx_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_ack_i |=> !dma_rx_req_o);
  a_r10_err_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_i[FL_TEND] |=> !dma_tx_req_o);
endmodule

// File: rtl/sc_irq_ctrl.sv
module sc_irq_ctrl
  import sc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_end_i,
  input  logic             tx_nak_i,
  input  logic             rx_end_i,
  input  logic             rx_perr_i,
  input  logic             tie_i,
  input  logic             rie_i,
  input  logic             cpu_rd_i,
  input  logic             cpu_clr_i,
  input  logic [NFLAG-1:0] cpu_clr_mask_i,
  input  logic             dma_tx_ack_i,
  input  logic             dma_rx_ack_i,
  output logic [NFLAG-1:0] status_o,
  output logic             txi_o,
  output logic             rxi_o,
  output logic             eri_o,
  output logic             dma_tx_req_o,
  output logic             dma_rx_req_o,
  output logic             retx_req_o
);
  flag_vec_t set_v, hwclr_v, flags;

  sc_event_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_end_i     (tx_end_i),
    .tx_nak_i     (tx_nak_i),
    .rx_end_i     (rx_end_i),
    .rx_perr_i    (rx_perr_i),
    .rxf_i        (flags[FL_RXF]),
    .dma_tx_ack_i (dma_tx_ack_i),
    .dma_rx_ack_i (dma_rx_ack_i),
    .set_o        (set_v),
    .hwclr_o      (hwclr_v),
    .retx_o       (retx_req_o)
  );

  sc_flag_bank #(.RST_VAL(FLAG_RST)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_v),
    .hwclr_i    (hwclr_v),
    .cpu_rd_i   (cpu_rd_i),
    .cpu_clr_i  (cpu_clr_i),
    .cpu_mask_i (cpu_clr_mask_i),
    .flags_o    (flags)
  );

  sc_req_gen u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .flags_i      (flags),
    .tie_i        (tie_i),
    .rie_i        (rie_i),
    .dma_tx_ack_i (dma_tx_ack_i),
    .dma_rx_ack_i (dma_rx_ack_i),
    .txi_o        (txi_o),
    .rxi_o        (rxi_o),
    .eri_o        (eri_o),
    .dma_tx_req_o (dma_tx_req_o),
    .dma_rx_req_o (dma_rx_req_o)
  );

  assign status_o = flags;

  a_r2_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end_i && !tx_nak_i) |=> (status_o[FL_TXE] && status_o[FL_TEND]));
  a_r3_nak_no_tend: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end_i && tx_nak_i && !status_o[FL_TEND]) |=> !status_o[FL_TEND]);
  a_r3_nak_esig: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end_i && tx_nak_i) |=> status_o[FL_ESIG]);
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end_i && status_o[FL_RXF]) |=> status_o[FL_OVR]);
  a_r9_esig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[FL_ESIG] && !(cpu_clr_i && cpu_clr_mask_i[FL_ESIG])) |=> status_o[FL_ESIG]);
endmodule

// File: tb/sc_irq_ctrl_tb_top.sv
module sc_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_end_i = 0, tx_nak_i = 0, rx_end_i = 0, rx_perr_i = 0;
  logic tie_i = 0, rie_i = 0, cpu_rd_i = 0, cpu_clr_i = 0;
  logic [5:0] cpu_clr_mask_i = '0;
  logic dma_tx_ack_i = 0, dma_rx_ack_i = 0;
  logic [5:0] status_o;
  logic txi_o, rxi_o, eri_o, dma_tx_req_o, dma_rx_req_o, retx_req_o;

  always #2 clk = ~clk;

  sc_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_end_i(tx_end_i), .tx_nak_i(tx_nak_i),
    .rx_end_i(rx_end_i), .rx_perr_i(rx_perr_i),
    .tie_i(tie_i), .rie_i(rie_i),
    .cpu_rd_i(cpu_rd_i), .cpu_clr_i(cpu_clr_i), .cpu_clr_mask_i(cpu_clr_mask_i),
    .dma_tx_ack_i(dma_tx_ack_i), .dma_rx_ack_i(dma_rx_ack_i),
    .status_o(status_o), .txi_o(txi_o), .rxi_o(rxi_o), .eri_o(eri_o),
    .dma_tx_req_o(dma_tx_req_o), .dma_rx_req_o(dma_rx_req_o), .retx_req_o(retx_req_o)
  );

  typedef struct {
    logic [5:0] st;
    logic [5:0] outs; // {txi,rxi,eri,dtx,drx,retx}
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the requirements
  logic [5:0] m_fl = 6'b000011, m_arm = '0;
  logic m_tie = 0, m_rie = 0;

  task automatic step(input logic te, nk, re, pe, ta, ra, rd, cl,
                      input logic [5:0] mk, input string tag);
    logic [5:0] set, hw, kill, nxt;
    exp_t e;
    @(negedge clk);
    tx_end_i = te; tx_nak_i = nk; rx_end_i = re; rx_perr_i = pe;
    dma_tx_ack_i = ta; dma_rx_ack_i = ra; cpu_rd_i = rd; cpu_clr_i = cl;
    cpu_clr_mask_i = mk; tie_i = m_tie; rie_i = m_rie;
    set = '0;
    if (te) begin
      if (nk) set[5] = 1; else begin set[0] = 1; set[1] = 1; end
    end
    if (re) begin
      if (m_fl[2]) set[4] = 1; else if (pe) set[3] = 1; else set[2] = 1;
    end
    hw = {3'b000, ra, ta, ta};
    kill = cl ? (mk & m_arm) : 6'b0;
    nxt = (m_fl & ~hw & ~kill) | set;
    e.outs[2] = m_fl[1] & m_tie & ~ta;
    e.outs[1] = m_fl[2] & m_rie & ~ra;
    e.outs[0] = te & nk;
    m_arm = (m_arm | (rd ? m_fl : 6'b0)) & nxt;
    m_fl = nxt;
    e.st = nxt;
    e.outs[5] = nxt[1] & m_tie;
    e.outs[4] = nxt[2] & m_rie;
    e.outs[3] = (nxt[3] | nxt[4] | nxt[5]) & m_rie;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 6'b0, tag);
  endtask

  // monitor
  initial begin
    exp_t e;
    logic [5:0] got;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        got = {txi_o, rxi_o, eri_o, dma_tx_req_o, dma_rx_req_o, retx_req_o};
        checks++;
        if (got !== e.outs || status_o !== e.st) begin
          errors++;
          $display("FAIL %s: status=%b outs=%b expected status=%b outs=%b",
                   e.tag, status_o, got, e.st, e.outs);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    m_tie = 1; idle("R4 txi follows enable, R10 tx request");
    step(0,0,0,0,1,0,0,0,6'b0, "R9 tx ack clears, R10 request drops");
    step(1,1,0,0,0,0,0,0,6'b0, "R3 nak sets error flag and retransmit");
    idle("R3 retransmit is one cycle");
    m_rie = 1; idle("R6 error interrupt, R10 no dma from error");
    step(0,0,0,0,1,0,0,0,6'b0, "R9 ack keeps error flag");
    step(1,0,0,0,0,0,0,0,6'b0, "R2 clean end sets empty and end");
    idle("R10 tx request rises");
    step(0,0,1,0,0,0,0,0,6'b0, "R7 receive sets full, R5 rxi");
    idle("R10 rx request rises");
    step(0,0,1,1,0,0,0,0,6'b0, "R8 overrun keeps full");
    step(0,0,0,0,0,1,0,0,6'b0, "R9 rx ack clears full only");
    step(0,0,1,1,0,0,0,0,6'b0, "R7 parity error no full");
    step(0,0,0,0,0,0,0,1,6'b100000, "R11 unarmed clear ignored");
    step(0,0,0,0,0,0,1,0,6'b0, "R11 read arms");
    step(0,0,0,0,0,0,0,1,6'b101000, "R11 armed clear");
    step(0,0,1,0,0,0,0,0,6'b0, "R7 receive again");
    step(0,0,0,0,0,0,1,0,6'b0, "R11 read arms overrun");
    step(0,0,1,0,0,0,0,1,6'b010000, "R12 overrun set beats clear");
    step(0,0,0,0,0,0,1,0,6'b0, "R11 read arms end");
    step(1,0,0,0,0,0,0,1,6'b000010, "R12 end set beats clear");
    m_rie = 0; idle("R6 disabled error interrupt, R5 disabled rxi");
    m_tie = 0; idle("R4 disabled txi");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule